// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is a slave serial port that holds eight 9-bit setup registers for an imaging front end. An external host drives three pins: an active-low frame select, a serial clock and a bidirectional data line (presented here as a separate input, output and output enable). Each frame is 13 bits long. It carries a direction flag, a 3-bit register address and a 9-bit data word. A write frame updates the addressed register. A read frame turns the data line around after the address, and the port shifts the stored word back to the host.

All three pins are oversampled by the system clock through two-flop synchronizers. The clock edges are found in the sampled domain, so the serial clock must be at least a few times slower than the system clock. The register file resets to its defined defaults and forces every reserved bit to zero. It exports the stored settings as decoded fields: the mode flags, the channel order and channel enables, three 6-bit gains and three 9-bit sign-magnitude offsets. Each offset is also given as a 9-bit two's-complement value.

Top module: `sreg_port`

## Requirements
- R1: After reset, register 0 holds 0x0F8, register 1 holds 0x0C0 and registers 2 to 7 hold 0. Both the decoded outputs and read frames show these values.
- R2: A frame is sent most significant bit first, in this order: the direction flag (0 = write, 1 = read), then address bits 2..0, then data bits 8..0. Each bit is taken on a rising edge of the serial clock. A complete write frame stores its data in the addressed register.
- R3: A write is stored only if exactly 13 rising serial-clock edges were seen when the frame select returns high. A frame with fewer or more edges leaves every register unchanged.
- R4: Reserved bits are stored and read back as 0. The kept-bit masks are 0x0FD for address 0, 0x0F0 for address 1, 0x03F for addresses 2 to 4 and 0x1FF for addresses 5 to 7.
- R5: In a read frame, the port presents data bit 8 after the falling serial-clock edge that follows the last address bit. Each later falling edge presents the next lower bit. The returned word equals the stored value, and the read changes no register.
- R6: The data output enable is high only in the data phase of a read frame. It is low in write frames, during the address phase, after the 13th bit and whenever the frame select is high.
- R7: Address 0 decodes as follows: bit 7 = wide input range, bit 6 = internal reference, bit 5 = three-channel, bit 4 = correlated sampling, bit 3 = high clamp level, bit 2 = sleep, bit 0 = single-byte output. Address 1 decodes as bit 7 = forward channel order and bits 6/5/4 = red/green/blue enable, presented as mux_sel[2]/[1]/[0].
- R8: Addresses 2/3/4 are the red/green/blue gains in bits 5..0. They appear on gain_q[5:0], [11:6] and [17:12]. Addresses 5/6/7 are the red/green/blue offsets. They appear on offs_sm[8:0], [17:9] and [26:18].
- R9: Each offs_tc field is the two's-complement form of the matching offset. Bit 8 of the offset is the sign and bits 7..0 are the magnitude. A negative zero maps to 0.
- R10: Setting the sleep bit does not clear or change any register. Read and write access keep working while it is set.
- R11: A frame cut short by the frame select going high is dropped. The next frame starts again at the direction flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_n | input | 1 | Frame select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Drive enable for the shared data line |
| cfg_wide_range | output | 1 | Wide input range selected |
| cfg_int_ref | output | 1 | Internal reference enabled |
| cfg_three_ch | output | 1 | Three-channel operation |
| cfg_cds | output | 1 | Correlated sampling selected (0 = sample-hold) |
| cfg_clamp_hi | output | 1 | High clamp bias level |
| cfg_sleep | output | 1 | Sleep request |
| cfg_byte_mode | output | 1 | Single-byte output mode |
| mux_fwd | output | 1 | Forward channel order |
| mux_sel | output | 3 | Channel enables: [2] red, [1] green, [0] blue |
| gain_q | output | 18 | Three 6-bit gains, red in the lowest bits |
| offs_sm | output | 27 | Three 9-bit sign-magnitude offsets, red in the lowest bits |
| offs_tc | output | 27 | Three 9-bit two's-complement offsets, red in the lowest bits |

## Verification
The assertions check four things on every cycle:
- the output enable never rises outside the data phase of a read, and it falls once the frame select is high;
- the bit counter stays within its saturating range;
- no register changes in a cycle without a commit;
- the reserved bits of the two mode registers stay at zero.

Other behaviours are only visible across a whole frame. These are whether a frame of the wrong length is dropped, whether the read word comes out in the right order and on the right edges, and whether the decoded fields and the offset conversion match the stored values. The bench scenarios show these using random writes mixed with short, long and aborted frames, read-backs of every register, and directed cases: reserved-bit writes, negative zero, the offset extremes and the sleep bit.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int DW      = 9;
  localparam int AW      = 3;
  localparam int NREG    = 1 << AW;
  localparam int FRAME   = 1 + AW + DW;
  localparam int CW      = $clog2(FRAME + 2);
  localparam int GW      = 6;
  localparam int NCH     = 3;

  localparam logic [AW-1:0] A_CFG  = 3'd0;
  localparam logic [AW-1:0] A_MUX  = 3'd1;
  localparam logic [AW-1:0] A_GAIN = 3'd2;
  localparam logic [AW-1:0] A_OFFS = 3'd5;

  localparam logic [DW-1:0] CFG_MASK = 9'h0FD;
  localparam logic [DW-1:0] MUX_MASK = 9'h0F0;
  localparam logic [DW-1:0] GN_MASK  = 9'h03F;
  localparam logic [DW-1:0] OF_MASK  = 9'h1FF;

  function automatic logic [DW-1:0] reg_mask(input logic [AW-1:0] a);
    if (a == A_CFG)      return CFG_MASK;
    else if (a == A_MUX) return MUX_MASK;
    else if (a < A_OFFS) return GN_MASK;
    else                 return OF_MASK;
  endfunction

  function automatic logic [DW-1:0] reg_default(input logic [AW-1:0] a);
    if (a == A_CFG)      return 9'h0F8;
    else if (a == A_MUX) return 9'h0C0;
    else                 return '0;
  endfunction
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
  import sreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ss_n_s,
  input  logic          sck_s,
  input  logic          sdi_s,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam logic [CW-1:0] FULL   = CW'(FRAME);
  localparam logic [CW-1:0] OVER   = CW'(FRAME + 1);
  localparam logic [CW-1:0] HDR    = CW'(1 + AW);

  logic             sck_q, sck_d;
  logic             ss_q, ss_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [FRAME-1:0] shf_q, shf_d;
  logic             rw_q, rw_d;
  logic [DW-1:0]    out_q, out_d;
  logic             oe_q, oe_d;

  logic sck_rise, sck_fall, frame_end, active;

  assign sck_rise  = sck_s & ~sck_q;
  assign sck_fall  = ~sck_s & sck_q;
  assign active    = ~ss_n_s;
  assign frame_end = ss_n_s & ~ss_q;

  always_comb begin
    sck_d = sck_s;
    ss_d  = ss_n_s;
    cnt_d = cnt_q;
    shf_d = shf_q;
    rw_d  = rw_q;
    out_d = out_q;
    oe_d  = oe_q;
    if (!active) begin
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (sck_rise) begin
      if (cnt_q < FULL) shf_d = {shf_q[FRAME-2:0], sdi_s};
      if (cnt_q == '0)  rw_d  = sdi_s;
      if (cnt_q != OVER) cnt_d = cnt_q + 1'b1;
    end else if (sck_fall && rw_q) begin
      if (cnt_q == HDR) begin
        out_d = rd_word;
        oe_d  = 1'b1;
      end else if (cnt_q > HDR && cnt_q < FULL) begin
        out_d = {out_q[DW-2:0], 1'b0};
      end else if (cnt_q >= FULL) begin
        oe_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      ss_q  <= 1'b1;
      cnt_q <= '0;
      shf_q <= '0;
      rw_q  <= 1'b0;
      out_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      sck_q <= sck_d;
      ss_q  <= ss_d;
      cnt_q <= cnt_d;
      shf_q <= shf_d;
      rw_q  <= rw_d;
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  assign rd_addr = shf_q[AW-1:0];
  assign wr_en   = frame_end && (cnt_q == FULL) && !rw_q;
  assign wr_addr = shf_q[FRAME-2 -: AW];
  assign wr_data = shf_q[DW-1:0];
  assign sdo     = out_q[DW-1];
  assign sdo_oe  = oe_q;

  AST_OE_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (rw_q && cnt_q >= HDR)); // R6
  AST_OE_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_s |=> !oe_q); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= OVER); // R3
endmodule

// File: rtl/sreg_file.sv
module sreg_file
  import sreg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [AW-1:0]            rd_addr,
  output logic [DW-1:0]            rd_word,
  output logic [NREG-1:0][DW-1:0]  regs
);
  logic [NREG-1:0][DW-1:0] mem_q, mem_d;

  always_comb begin
    mem_d = mem_q;
    if (wr_en) mem_d[wr_addr] = wr_data & reg_mask(wr_addr);
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mem_q[i] <= reg_default(AW'(i));
      else if (wr_en) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_word = mem_q[rd_addr];
  assign regs    = mem_q;

  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q)); // R10
  AST_RSV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_q[0] & ~CFG_MASK) == '0) && ((mem_q[1] & ~MUX_MASK) == '0)); // R4
endmodule

// File: rtl/sreg_offs_cvt.sv
module sreg_offs_cvt
  import sreg_pkg::*;
(
  input  logic [DW-1:0] sm,
  output logic [DW-1:0] tc
);
  logic [DW-1:0] mag;
  assign mag = {1'b0, sm[DW-2:0]};
  assign tc  = sm[DW-1] ? (~mag + 1'b1) : mag;
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              cfg_wide_range,
  output logic              cfg_int_ref,
  output logic              cfg_three_ch,
  output logic              cfg_cds,
  output logic              cfg_clamp_hi,
  output logic              cfg_sleep,
  output logic              cfg_byte_mode,
  output logic              mux_fwd,
  output logic [2:0]        mux_sel,
  output logic [NCH*GW-1:0] gain_q,
  output logic [NCH*DW-1:0] offs_sm,
  output logic [NCH*DW-1:0] offs_tc
);
  logic                    ss_n_s, sck_s, sdi_s;
  logic [AW-1:0]           rd_addr, wr_addr;
  logic [DW-1:0]           rd_word, wr_data;
  logic                    wr_en;
  logic [NREG-1:0][DW-1:0] regs;

  sreg_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ss_n, sck, sdi}),
    .q({ss_n_s, sck_s, sdi_s})
  );

  sreg_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .ss_n_s(ss_n_s), .sck_s(sck_s), .sdi_s(sdi_s),
    .rd_word(rd_word), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  sreg_file u_file (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_word(rd_word), .regs(regs)
  );

  assign cfg_wide_range = regs[A_CFG][7];
  assign cfg_int_ref    = regs[A_CFG][6];
  assign cfg_three_ch   = regs[A_CFG][5];
  assign cfg_cds        = regs[A_CFG][4];
  assign cfg_clamp_hi   = regs[A_CFG][3];
  assign cfg_sleep      = regs[A_CFG][2];
  assign cfg_byte_mode  = regs[A_CFG][0];
  assign mux_fwd        = regs[A_MUX][7];
  assign mux_sel        = regs[A_MUX][6:4];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign gain_q[c*GW +: GW]  = regs[int'(A_GAIN) + c][GW-1:0];
    assign offs_sm[c*DW +: DW] = regs[int'(A_OFFS) + c];
    sreg_offs_cvt u_cvt (
      .sm(regs[int'(A_OFFS) + c]),
      .tc(offs_tc[c*DW +: DW])
    );
  end
endmodule

// File: tb/sreg_port_tb.sv
module sreg_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ss_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic cfg_wide_range, cfg_int_ref, cfg_three_ch, cfg_cds, cfg_clamp_hi, cfg_sleep, cfg_byte_mode;
  logic mux_fwd;
  logic [2:0]  mux_sel;
  logic [17:0] gain_q;
  logic [26:0] offs_sm, offs_tc;

  int n_chk = 0, n_bad = 0;
  logic [8:0] mdl [8];

  always #10 clk = ~clk;

  sreg_port u_dut (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe),
    .cfg_wide_range(cfg_wide_range), .cfg_int_ref(cfg_int_ref),
    .cfg_three_ch(cfg_three_ch), .cfg_cds(cfg_cds), .cfg_clamp_hi(cfg_clamp_hi),
    .cfg_sleep(cfg_sleep), .cfg_byte_mode(cfg_byte_mode),
    .mux_fwd(mux_fwd), .mux_sel(mux_sel),
    .gain_q(gain_q), .offs_sm(offs_sm), .offs_tc(offs_tc)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] keep(input int a);
    case (a)
      0: return 9'h0FD;
      1: return 9'h0F0;
      2, 3, 4: return 9'h03F;
      default: return 9'h1FF;
    endcase
  endfunction

  function automatic logic [8:0] to_tc(input logic [8:0] s);
    logic [8:0] m;
    m = {1'b0, s[7:0]};
    return s[8] ? 9'(-m) : m;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends nbits of a frame; returns the read word and whether the enable misbehaved.
  task automatic xfer(input bit rw, input logic [2:0] a, input logic [8:0] d, input int nbits,
                      output logic [8:0] rd, output bit oe_bad);
    logic [12:0] f;
    f = {rw, a, d};
    rd = '0;
    oe_bad = 1'b0;
    ss_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 13) ? f[12-i] : 1'b0;
      wait_clk(8);
      if (rw && i >= 4 && i < 13) begin
        rd[12-i] = sdo;
        if (!sdo_oe) oe_bad = 1'b1;
      end else if (sdo_oe) oe_bad = 1'b1;
      sck = 1'b1;
      wait_clk(8);
      sck = 1'b0;
    end
    wait_clk(8);
    if (sdo_oe) oe_bad = 1'b1;
    ss_n = 1'b1;
    wait_clk(8);
    if (sdo_oe) oe_bad = 1'b1;
  endtask

  task automatic wr(input int a, input logic [8:0] d, input int nbits);
    logic [8:0] rd;
    bit bad;
    xfer(1'b0, 3'(a), d, nbits, rd, bad);
    chk(!bad, "R6 enable during write", 32'(bad), 0);
    if (nbits == 13) mdl[a] = d & keep(a);
  endtask

  task automatic rd_chk(input int a, input string req);
    logic [8:0] rd;
    bit bad;
    xfer(1'b1, 3'(a), 9'h0, 13, rd, bad);
    chk(rd === mdl[a], req, 32'(rd), 32'(mdl[a]));
    chk(!bad, "R6 enable only in read data phase", 32'(bad), 0);
  endtask

  task automatic fields_chk();
    chk({cfg_wide_range, cfg_int_ref, cfg_three_ch, cfg_cds, cfg_clamp_hi, cfg_sleep, cfg_byte_mode}
        === {mdl[0][7:2], mdl[0][0]}, "R7 config fields",
        32'({cfg_wide_range, cfg_int_ref, cfg_three_ch, cfg_cds, cfg_clamp_hi, cfg_sleep, cfg_byte_mode}),
        32'({mdl[0][7:2], mdl[0][0]}));
    chk({mux_fwd, mux_sel} === mdl[1][7:4], "R7 mux fields", 32'({mux_fwd, mux_sel}), 32'(mdl[1][7:4]));
    chk(gain_q === {mdl[4][5:0], mdl[3][5:0], mdl[2][5:0]}, "R8 gains",
        32'(gain_q), 32'({mdl[4][5:0], mdl[3][5:0], mdl[2][5:0]}));
    chk(offs_sm === {mdl[7], mdl[6], mdl[5]}, "R8 offsets", 32'(offs_sm), 32'({mdl[7], mdl[6], mdl[5]}));
    chk(offs_tc === {to_tc(mdl[7]), to_tc(mdl[6]), to_tc(mdl[5])}, "R9 two's complement",
        32'(offs_tc), 32'({to_tc(mdl[7]), to_tc(mdl[6]), to_tc(mdl[5])}));
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    for (int i = 0; i < 8; i++) mdl[i] = (i == 0) ? 9'h0F8 : (i == 1) ? 9'h0C0 : 9'h000;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1 reset state
    chk(sdo_oe === 1'b0, "R1 enable low after reset", 32'(sdo_oe), 0);
    fields_chk();
    for (int i = 0; i < 8; i++) rd_chk(i, "R1 reset value read");

    // R2/R4 reserved bits on every register
    for (int i = 0; i < 8; i++) begin
      wr(i, 9'h1FF, 13);
      rd_chk(i, "R4 reserved bits read as zero");
    end
    fields_chk();

    // R9 offset corners: negative zero, -255, +255
    wr(5, 9'h100, 13);
    wr(6, 9'h1FF, 13);
    wr(7, 9'h0FF, 13);
    chk(offs_tc[8:0] === 9'h000, "R9 negative zero", 32'(offs_tc[8:0]), 0);
    chk(offs_tc[17:9] === 9'h101, "R9 minus 255", 32'(offs_tc[17:9]), 32'h101);
    chk(offs_tc[26:18] === 9'h0FF, "R9 plus 255", 32'(offs_tc[26:18]), 32'h0FF);

    // R3/R11 short frame then good frame, long frame
    wr(3, 9'h015, 7);
    fields_chk();
    wr(3, 9'h02A, 13);
    rd_chk(3, "R11 frame after abort");
    wr(2, 9'h011, 14);
    rd_chk(2, "R3 long frame dropped");

    // R10 sleep keeps contents and access
    wr(0, 9'h004, 13);
    chk(cfg_sleep === 1'b1, "R10 sleep set", 32'(cfg_sleep), 1);
    for (int i = 1; i < 8; i++) rd_chk(i, "R10 contents kept in sleep");
    wr(4, 9'h033, 13);
    rd_chk(4, "R10 write during sleep");
    rd_chk(4, "R5 read does not disturb");

    // Random mix
    for (int k = 0; k < 60; k++) begin
      int a, kind, nb;
      a = int'($urandom_range(7, 0));
      kind = int'($urandom_range(9, 0));
      nb = (kind < 7) ? 13 : (kind == 7) ? int'($urandom_range(12, 1)) : int'($urandom_range(16, 14));
      wr(a, 9'($urandom), nb);
      fields_chk();
      if (kind[0]) rd_chk(int'($urandom_range(7, 0)), "R2 R5 random read-back");
    end
    for (int i = 0; i < 8; i++) rd_chk(i, "R5 final read-back");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule